// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block keeps a five-bit condition register that is loaded from a compare of two 32-bit operands, and uses that register to resolve conditional branches. When a compare strobe is present, the block records separate signed and unsigned greater and less results, or only an equality mark when the operands match. The register takes the new value at the next clock edge.

A branch instruction word is presented together with a valid strobe and the address of the branch. In the same cycle, the block decides from the stored flags whether the branch is taken. It then produces the address of the next instruction:

- A taken branch goes to the branch address plus a sign-extended, doubled 10-bit displacement, plus the normal 2-byte step.
- Any other instruction advances by the 2-byte step only.

Condition codes outside the ten defined ones raise an illegal-instruction flag instead. The block sits beside the decode stage of a small 32-bit core. The core supplies operands, instruction words and the current address, and it consumes the taken flag and the next address.

Top module: `cmpbr_unit`

## Requirements
- R1: While reset is held and directly after it, the condition register reads zero.
- R2: A compare of equal operands loads the register with exactly 5'b00100. The bit layout is: bit 0 signed greater, bit 1 signed less, bit 2 equal, bit 3 unsigned greater, bit 4 unsigned less.
- R3: A compare of unequal operands clears bit 2. It sets exactly one of bits 0/1 by two's-complement order and exactly one of bits 3/4 by unsigned order.
- R4: The register changes only at a clock edge where the compare strobe is high, and is visible from that edge on. Without the strobe it holds, whatever the operands do.
- R5: A word is a branch only when the valid strobe is high and instruction bits 15 and 14 are both 1. For any other word or with the strobe low, taken and illegal are 0 and next_pc is cur_pc + 2.
- R6: The condition field sits in bits 13:10. Codes 0 to 5 take the branch, in order, on: bit 2 set; bit 2 clear; bit 1; bit 0; bit 4; bit 3.
- R7: Codes 6 to 9 take the branch on an OR with bit 2, in order: bit 0 or bit 2; bit 1 or bit 2; bit 3 or bit 2; bit 4 or bit 2.
- R8: The displacement is bits 9:0 of the instruction, sign-extended and doubled. A taken branch gives next_pc = cur_pc + displacement + 2, modulo 2^32.
- R9: A valid branch whose condition fails gives taken = 0 and next_pc = cur_pc + 2.
- R10: Codes 10 to 15 raise illegal, give taken = 0 and next_pc = cur_pc + 2, and leave the condition register unchanged.
- R11: taken and next_pc are combinational in the cycle of the valid strobe. A compare strobed in the same cycle affects only later branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Instruction word valid |
| br_insn | input | 16 | Instruction word |
| cur_pc | input | 32 | Address of the presented instruction |
| cc_flags | output | 5 | Registered condition flags |
| br_taken | output | 1 | Branch taken this cycle |
| next_pc | output | 32 | Address of the following instruction |
| br_illegal | output | 1 | Undefined branch condition code |

## Verification
A compare and a branch can arrive in the same cycle, and the branch must then be resolved on the flags stored before that compare. The bench provokes this by holding the flags at a non-equal result, then strobing an equal compare and a branch-if-equal together. It requires not-taken with a 2-byte step in that cycle, and taken with the displaced address once the edge has passed. An illegal condition code strobed beside a held register is judged the same way, by reading the flags after the edge.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
    localparam int FLAG_W = 5;
    localparam int FL_SGT = 0;
    localparam int FL_SLT = 1;
    localparam int FL_EQ  = 2;
    localparam int FL_UGT = 3;
    localparam int FL_ULT = 4;
    localparam int COND_W = 4;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef enum logic [COND_W-1:0] {
        CND_EQ  = 4'd0,
        CND_NE  = 4'd1,
        CND_SLT = 4'd2,
        CND_SGT = 4'd3,
        CND_ULT = 4'd4,
        CND_UGT = 4'd5,
        CND_SGE = 4'd6,
        CND_SLE = 4'd7,
        CND_UGE = 4'd8,
        CND_ULE = 4'd9
    } cond_e;

    typedef struct packed {
        flags_t flags;
    } state_t;
endpackage

// File: rtl/cmpbr_flag_gen.sv
module cmpbr_flag_gen
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output flags_t            flags
);
    always_comb begin
        flags = '0;
        if (op_a == op_b) begin
            flags[FL_EQ] = 1'b1;
        end else begin
            flags[FL_SGT] = $signed(op_a) > $signed(op_b);
            flags[FL_SLT] = $signed(op_a) < $signed(op_b);
            flags[FL_UGT] = op_a > op_b;
            flags[FL_ULT] = op_a < op_b;
        end
    end
endmodule

// File: rtl/cmpbr_cond_eval.sv
module cmpbr_cond_eval
    import cmpbr_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flags,
    output logic              hit,
    output logic              undefined
);
    always_comb begin
        hit       = 1'b0;
        undefined = 1'b0;
        case (cond)
            CND_EQ:  hit = flags[FL_EQ];
            CND_NE:  hit = !flags[FL_EQ];
            CND_SLT: hit = flags[FL_SLT];
            CND_SGT: hit = flags[FL_SGT];
            CND_ULT: hit = flags[FL_ULT];
            CND_UGT: hit = flags[FL_UGT];
            CND_SGE: hit = flags[FL_SGT] | flags[FL_EQ];
            CND_SLE: hit = flags[FL_SLT] | flags[FL_EQ];
            CND_UGE: hit = flags[FL_UGT] | flags[FL_EQ];
            CND_ULE: hit = flags[FL_ULT] | flags[FL_EQ];
            default: undefined = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmpbr_disp_ext.sv
module cmpbr_disp_ext #(
    parameter int INSN_W = 16,
    parameter int OFS_W  = 10,
    parameter int ADDR_W = 32
) (
    input  logic [INSN_W-1:0] insn,
    output logic [ADDR_W-1:0] disp
);
    localparam int EXT_W = ADDR_W - OFS_W - 1;

    assign disp = {{EXT_W{insn[OFS_W-1]}}, insn[OFS_W-1:0], 1'b0};
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
    import cmpbr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int INSN_W = 16,
    parameter int OFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              br_valid,
    input  logic [INSN_W-1:0] br_insn,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic [FLAG_W-1:0] cc_flags,
    output logic              br_taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic              br_illegal
);
    localparam int COND_HI = INSN_W - 3;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    state_t state_d, state_q;
    flags_t cmp_flags;
    logic   cond_hit, cond_bad, is_branch;
    logic [ADDR_W-1:0] disp;

    cmpbr_flag_gen #(.DATA_W(DATA_W)) u_flag_gen (
        .op_a  (cmp_a),
        .op_b  (cmp_b),
        .flags (cmp_flags)
    );

    cmpbr_cond_eval u_cond_eval (
        .cond      (br_insn[COND_HI -: COND_W]),
        .flags     (state_q.flags),
        .hit       (cond_hit),
        .undefined (cond_bad)
    );

    cmpbr_disp_ext #(
        .INSN_W (INSN_W),
        .OFS_W  (OFS_W),
        .ADDR_W (ADDR_W)
    ) u_disp_ext (
        .insn (br_insn),
        .disp (disp)
    );

    always_comb begin
        state_d = state_q;
        if (cmp_valid) begin
            state_d.flags = cmp_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign is_branch  = br_valid && br_insn[INSN_W-1] && br_insn[INSN_W-2];
    assign br_taken   = is_branch && cond_hit && !cond_bad;
    assign br_illegal = is_branch && cond_bad;
    assign next_pc    = cur_pc + STEP + (br_taken ? disp : '0);
    assign cc_flags   = state_q.flags;
endmodule

// File: rtl/cmpbr_unit_chk.sv
module cmpbr_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int INSN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic [DATA_W-1:0] cmp_a,
    input logic [DATA_W-1:0] cmp_b,
    input logic              br_valid,
    input logic [INSN_W-1:0] br_insn,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [4:0]        cc_flags,
    input logic              br_taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic              br_illegal
);
    // R2
    eq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && (cmp_a == cmp_b) |=> cc_flags == 5'b00100);

    // R3
    ne_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && (cmp_a != cmp_b) |=> !cc_flags[2] && ($countones(cc_flags) == 2));

    // R4
    hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(cc_flags));

    // R5
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> !br_taken && !br_illegal);

    // R9
    step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> next_pc == cur_pc + ADDR_W'(2));

    // R10
    illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_illegal |-> !br_taken && br_insn[INSN_W-1] && br_insn[INSN_W-2]
                       && (br_insn[INSN_W-3 -: 4] >= 4'd10));
endmodule

bind cmpbr_unit cmpbr_unit_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .INSN_W (INSN_W)
) u_chk (.*);

// File: tb/cmpbr_unit_tb.sv
`timescale 1ns/1ps
module cmpbr_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_valid;
    logic [31:0] cmp_a, cmp_b;
    logic        br_valid;
    logic [15:0] br_insn;
    logic [31:0] cur_pc;
    logic [4:0]  cc_flags;
    logic        br_taken;
    logic [31:0] next_pc;
    logic        br_illegal;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cmpbr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .br_valid(br_valid), .br_insn(br_insn), .cur_pc(cur_pc), .cc_flags(cc_flags),
        .br_taken(br_taken), .next_pc(next_pc), .br_illegal(br_illegal)
    );

    // {operand a, operand b, displacement field, expected flags}
    localparam logic [78:0] VEC [8] = '{
        {32'h0000_0005, 32'h0000_0005, 10'h004, 5'h04},
        {32'h0000_0003, 32'h0000_0007, 10'h3F0, 5'h12},
        {32'h0000_0007, 32'h0000_0003, 10'h010, 5'h09},
        {32'hFFFF_FFFF, 32'h0000_0001, 10'h200, 5'h0A},
        {32'h0000_0001, 32'hFFFF_FFFF, 10'h1FF, 5'h11},
        {32'h8000_0000, 32'h7FFF_FFFF, 10'h001, 5'h0A},
        {32'h0000_0000, 32'h0000_0000, 10'h3FF, 5'h04},
        {32'hFFFF_FFFF, 32'hFFFF_FFFE, 10'h055, 5'h09}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic want_taken(input logic [3:0] c, input logic [4:0] f);
        case (c)
            4'd0: return f[2];
            4'd1: return !f[2];
            4'd2: return f[1];
            4'd3: return f[0];
            4'd4: return f[4];
            4'd5: return f[3];
            4'd6: return f[0] | f[2];
            4'd7: return f[1] | f[2];
            4'd8: return f[3] | f[2];
            4'd9: return f[4] | f[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] want_pc(input logic [31:0] pc, input logic t,
                                            input logic [9:0] o);
        return pc + 32'd2 + (t ? {{21{o[9]}}, o, 1'b0} : 32'd0);
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmp_valid = 1'b0; cmp_a = '0; cmp_b = '0;
        br_valid = 1'b0; br_insn = '0; cur_pc = '0;
        repeat (3) @(negedge clk);
        #1 chk("R1 flags in reset", 32'(cc_flags), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1 flags after reset", 32'(cc_flags), 32'h0);

        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cmp_a = VEC[i][78:47]; cmp_b = VEC[i][46:15]; cmp_valid = 1'b1;
            @(negedge clk);
            cmp_valid = 1'b0;
            #1 chk(VEC[i][4:0] == 5'h04 ? "R2 equal flags" : "R3 unequal flags",
                   32'(cc_flags), 32'(VEC[i][4:0]));
            for (int c = 0; c < 16; c++) begin
                logic t;
                t = want_taken(4'(c), VEC[i][4:0]);
                br_valid = 1'b1;
                br_insn  = {2'b11, 4'(c), VEC[i][14:5]};
                cur_pc   = 32'h0000_1000 + 32'(i * 64);
                #1;
                chk(c < 6 ? "R6 taken" : (c < 10 ? "R7 taken" : "R10 taken"),
                    32'(br_taken), 32'(t));
                chk("R10 illegal", 32'(br_illegal), 32'(c >= 10));
                chk(t ? "R8 next_pc" : "R9 next_pc", next_pc, want_pc(cur_pc, t, VEC[i][14:5]));
            end
            br_valid = 1'b0;
        end

        // R4: operands move without strobe
        @(negedge clk);
        cmp_a = 32'd1; cmp_b = 32'd2;
        repeat (2) @(negedge clk);
        #1 chk("R4 hold", 32'(cc_flags), 32'h09);

        // R5: not a branch word, and strobe low
        br_valid = 1'b1; br_insn = {2'b10, 4'd3, 10'h004}; cur_pc = 32'h0000_0400;
        #1 chk("R5 non-branch taken", 32'(br_taken), 32'h0);
        chk("R5 non-branch pc", next_pc, 32'h0000_0402);
        br_valid = 1'b0; br_insn = {2'b11, 4'd3, 10'h004};
        #1 chk("R5 strobe low taken", 32'(br_taken), 32'h0);
        chk("R5 strobe low illegal", 32'(br_illegal), 32'h0);

        // R11: compare and branch in one cycle
        @(negedge clk);
        cmp_a = 32'd5; cmp_b = 32'd5; cmp_valid = 1'b1;
        br_valid = 1'b1; br_insn = {2'b11, 4'd0, 10'h010}; cur_pc = 32'h0000_2000;
        #1 chk("R11 same-cycle taken", 32'(br_taken), 32'h0);
        chk("R11 same-cycle pc", next_pc, 32'h0000_2002);
        @(negedge clk);
        cmp_valid = 1'b0;
        #1 chk("R11 later taken", 32'(br_taken), 32'h1);
        chk("R11 later pc", next_pc, 32'h0000_2022);

        // R10: illegal code leaves flags alone
        br_insn = {2'b11, 4'd14, 10'h010};
        #1 chk("R10 illegal flag", 32'(br_illegal), 32'h1);
        @(negedge clk);
        #1 chk("R10 flags kept", 32'(cc_flags), 32'h04);

        // R8: displacement extremes and wrap
        br_insn = {2'b11, 4'd0, 10'h200}; cur_pc = 32'h0000_8000;
        #1 chk("R8 most negative", next_pc, 32'h0000_7C02);
        br_insn = {2'b11, 4'd0, 10'h1FF};
        #1 chk("R8 most positive", next_pc, 32'h0000_8400);
        br_insn = {2'b11, 4'd0, 10'h3FF}; cur_pc = 32'h0000_0000;
        #1 chk("R8 wrap to zero", next_pc, 32'h0000_0000);
        br_valid = 1'b0;

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule